// File: doc/BRIEF.md
# Tracking ADC Counter Controller

This block is the digital half of a continuous tracking (servo) analog-to-digital converter. An external comparator reports one bit: high when the analog input sits above the current DAC output, low when it sits below. The block keeps an N-bit up/down count. That count drives the DAC code directly and is also presented as the conversion result. There is no start command and no end-of-conversion handshake. The result is always valid and follows the input one code per step.

The comparator bit is asynchronous to the block clock, so it passes through a two-flop synchronizer. A step-enable input sets the tracking rate: the count moves only on cycles where the enable is high. At the code limits the count saturates instead of wrapping. Once the DAC output has caught the input, the count settles into a one-LSB dither between two adjacent codes. A lock flag reports that state, based on the recent history of step directions.

Top module: `trk_adc_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count (and so `dac_code` and `result`) becomes mid-scale: MSB set, all other bits clear. `locked` becomes 0, and the step history and synchronizer are cleared to 0.
- R2: On an edge with `step_en` high, a synchronized comparator value of 1 increments the count by one. A value driven on `cmp_in` before edge k first steers the step taken at edge k+2.
- R3: On an edge with `step_en` high, a synchronized comparator value of 0 decrements the count by one, with the same two-edge synchronizer latency.
- R4: Counting up from all-ones leaves the count at all-ones; it never wraps to zero.
- R5: Counting down from zero leaves the count at zero; it never wraps to all-ones.
- R6: On an edge with `step_en` low, the count and `locked` keep their values whatever `cmp_in` does.
- R7: `dac_code` and `result` always carry the same value, the registered count, updated on the edge of each step.
- R8: A step reverses when its direction (1 = up, 0 = down) differs from that of the previous step since reset. A step still counts even if saturation held the count. `locked` is set on the edge of the step that completes four consecutive reversals and stays set while reversals continue.
- R9: A step in the same direction as the previous step (two steps in one direction) clears `locked` and restarts the reversal run at zero. The first step after reset also starts the run at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Step enable; one count step per high cycle |
| cmp_in | input | 1 | Asynchronous comparator bit: 1 = analog input above DAC output |
| dac_code | output | W | Code driven to the DAC |
| result | output | W | Continuous conversion result |
| locked | output | 1 | High while the count dithers by one LSB |

## Verification
The step-direction assertion assumes the comparator bit stays stable around the sampling edge. The two-cycle look-back it uses is valid only once two edges have passed since reset, so the checker counts those edges before it arms. The bench changes `cmp_in` only at falling edges, so each value is captured cleanly by the synchronizer.

For lock behaviour, the bench raises `step_en` only every third cycle. This lets each comparator decision reflect the code of the previous step despite the synchronizer latency. It also mixes in freely random comparator and enable patterns, plus long one-direction runs that hold the count at both limits.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } trk_dir_e;
endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/trk_updn.sv
module trk_updn
  import trk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  trk_dir_e     dir,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= MID;
    end else if (en) begin
      if (dir == DIR_UP) begin
        if (count != TOP) count <= count + 1'b1;
      end else begin
        if (count != ZERO) count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/trk_lock.sv
module trk_lock
  import trk_pkg::*;
#(
  parameter int REV_N = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  trk_dir_e dir,
  output logic     locked
);
  localparam int CW = $clog2(REV_N + 1);
  localparam logic [CW-1:0] REV_MAX = CW'(REV_N);

  logic          has_prev;
  trk_dir_e      last_dir;
  logic [CW-1:0] rev_cnt;
  logic [CW-1:0] rev_nxt;

  always_comb begin
    rev_nxt = rev_cnt;
    if (en) begin
      if (has_prev && (dir != last_dir)) begin
        if (rev_cnt != REV_MAX) rev_nxt = rev_cnt + 1'b1;
      end else begin
        rev_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      has_prev <= 1'b0;
      last_dir <= DIR_DOWN;
      rev_cnt  <= '0;
      locked   <= 1'b0;
    end else if (en) begin
      has_prev <= 1'b1;
      last_dir <= dir;
      rev_cnt  <= rev_nxt;
      locked   <= (rev_nxt == REV_MAX);
    end
  end
endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl
  import trk_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGE = 2,
  parameter int LOCK_REV   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         cmp_in,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] result,
  output logic         locked
);
  logic         cmp_s;
  trk_dir_e     dir;
  logic [W-1:0] count;

  trk_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (cmp_in),
    .d_out (cmp_s)
  );

  assign dir = cmp_s ? DIR_UP : DIR_DOWN;

  trk_updn #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (step_en),
    .dir   (dir),
    .count (count)
  );

  trk_lock #(.REV_N(LOCK_REV)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .en     (step_en),
    .dir    (dir),
    .locked (locked)
  );

  assign dac_code = count;
  assign result   = count;
endmodule

// File: rtl/trk_adc_ctrl_chk.sv
module trk_adc_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         step_en,
  input logic         cmp_in,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] result,
  input logic         locked
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R7: both outputs carry the same count
  always_comb begin
    assert_same_code_R7: assert (dac_code === result || $isunknown(dac_code));
  end

  assert_hold_no_en_R6: assert property (@(posedge clk) disable iff (rst)
    (!step_en && since_rst != 2'd0) |=> ($stable(dac_code) && $stable(locked)));

  assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (rst)
    (step_en && since_rst != 2'd0 && dac_code == TOP) |=> (dac_code != '0));

  assert_no_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && since_rst != 2'd0 && dac_code == '0) |=> (dac_code != TOP));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && since_rst == 2'd3 && $past(cmp_in, 2) && dac_code != TOP)
      |=> (dac_code == W'($past(dac_code) + 1'b1)));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (step_en && since_rst == 2'd3 && !$past(cmp_in, 2) && dac_code != '0)
      |=> (dac_code == W'($past(dac_code) - 1'b1)));
endmodule

bind trk_adc_ctrl trk_adc_ctrl_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step_en  (step_en),
  .cmp_in   (cmp_in),
  .dac_code (dac_code),
  .result   (result),
  .locked   (locked)
);

// File: tb/trk_adc_ctrl_bench.sv
module trk_adc_ctrl_bench;
  localparam int W      = 8;
  localparam int PERIOD = 10;
  localparam int REV_N  = 4;
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_en = 1'b0;
  logic         cmp_in = 1'b0;
  logic [W-1:0] dac_code;
  logic [W-1:0] result;
  logic         locked;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model state
  logic [W-1:0] m_cnt;
  bit m_s1, m_s2, m_has_prev, m_last, m_lock;
  int m_rev;

  always #(PERIOD/2) clk = ~clk;

  trk_adc_ctrl #(.W(W)) u_trk_adc_ctrl (
    .clk(clk), .rst(rst), .step_en(step_en), .cmp_in(cmp_in),
    .dac_code(dac_code), .result(result), .locked(locked)
  );

  function automatic logic [W-1:0] exp_step(logic [W-1:0] c, bit up);
    if (up)  return (c == TOP) ? c : c + 1'b1;
    else     return (c == '0)  ? c : c - 1'b1;
  endfunction

  function automatic int exp_rev(int rev, bit has_prev, bit last, bit dir);
    if (has_prev && dir != last) return (rev < REV_N) ? rev + 1 : rev;
    return 0;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at falling edge, advance model, compare at next falling edge
  task automatic cyc(bit en, bit cmp, bit do_rst, string req);
    step_en = en; cmp_in = cmp; rst = do_rst;
    @(posedge clk);
    if (do_rst) begin
      m_cnt = MID; m_s1 = 0; m_s2 = 0; m_has_prev = 0; m_last = 0; m_lock = 0; m_rev = 0;
    end else begin
      if (en) begin
        m_cnt = exp_step(m_cnt, m_s2);
        m_rev = exp_rev(m_rev, m_has_prev, m_last, m_s2);
        m_lock = (m_rev == REV_N);
        m_has_prev = 1; m_last = m_s2;
      end
      m_s2 = m_s1; m_s1 = cmp;
    end
    @(negedge clk);
    check({req, " dac_code"}, dac_code, m_cnt);
    check("R7 result", result, m_cnt);
    check({req, " locked"}, {{(W-1){1'b0}}, locked}, {{(W-1){1'b0}}, m_lock});
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int target;
    seed = 32'h1d2c;
    void'($urandom(seed));
    @(negedge clk);
    // R1 reset state
    cyc(0, 0, 1, "R1");
    cyc(1, 1, 1, "R1");
    // R2 up with synchronizer latency
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, "R2");
    // R3 down
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, "R3");
    // R6 enable low, comparator toggling
    for (int i = 0; i < 10; i++) cyc(0, i[0], 0, "R6");
    // R4 saturate high
    for (int i = 0; i < (1 << W) + 8; i++) cyc(1, 1, 0, "R4");
    // R5 saturate low
    for (int i = 0; i < (1 << W) + 8; i++) cyc(1, 0, 0, "R5");
    // R8 tracking a fixed level, one step every third cycle -> dither and lock
    cyc(0, 0, 1, "R1");
    target = 100;
    for (int i = 0; i < 3 * 60; i++)
      cyc((i % 3) == 2, (m_cnt <= target[W-1:0]), 0, "R8");
    if (!locked) begin
      total++; bad++;
      $display("FAIL R8: actual=%0d expected=1", locked);
    end
    // R9 two steps same direction clear the lock
    for (int i = 0; i < 9; i++) cyc((i % 3) == 2, 1, 0, "R9");
    // R8 again after re-entering dither
    for (int i = 0; i < 3 * 12; i++)
      cyc((i % 3) == 2, (m_cnt <= target[W-1:0]), 0, "R8");
    // random tracking with moving target and random enable
    for (int k = 0; k < 40; k++) begin
      target = $urandom_range(0, (1 << W) - 1);
      for (int i = 0; i < 3 * 30; i++)
        cyc((i % 3) == 2 || ($urandom_range(0, 9) == 0),
            (m_cnt <= target[W-1:0]), 0, "R2");
    end
    // fully random comparator and enable, occasional reset
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
          $urandom_range(0, 499) == 0, "R3");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule